// File: doc/BRIEF.md
# Four-Level Boost Mode Selector

This block sits between the digital pulse-width modulator of a single-phase power-factor-correction front end and the gate drivers of a boost stage whose output capacitor is split into an unequal divider: the lower cell holds one third of the bus and the upper cell two thirds. It takes the single PWM waveform from the current loop and steers it onto the two transistors. The mapping depends on the input-voltage region, which two comparators report: one trips at one third of the bus and one at two thirds. The mapping keeps the switching-node swing at one third of the bus in every region.

A start-up flag overrides region selection: while it is high, both transistors switch together as in a plain boost. Region changes are qualified and applied only at the start of a PWM period. Each change sends a one-clock preload command that re-seeds the current compensator's duty state at zero or full scale. The block also produces two one-clock sampling strobes for the divider voltages. Each strobe sits at the middle of the conduction interval in which that voltage can be read against its floating reference.

Top module: `mlb_mode_sel`

## Requirements
- R1: In the low region (mode code 1), the first gate is held high and the second gate follows the PWM.
- R2: In the middle region (mode code 2), the first gate follows the PWM and the second gate follows its complement.
- R3: In the high region (mode code 3), the first gate is held low and the second gate follows the PWM.
- R4: While the start-up input is high at a PWM rising edge, both gates follow the PWM from that edge on (start-up mapping, mode code 0). When the input is low at a rising edge during start-up, the mode jumps at once to the reported region. After reset the block is in start-up mapping.
- R5: The region is high when the two-thirds comparator is 1, otherwise middle when the one-third comparator is 1, and otherwise low. Outside start-up the mode moves by one region per change, so low to high passes through middle.
- R6: A region that differs from the mode must be seen, in the same direction, at two consecutive PWM rising edges before the mode changes. A single period of disagreement has no effect.
- R7: The mode changes only on the clock that samples a PWM rising edge. Gates reflect the PWM value sampled one clock earlier, and comparator inputs pass through two synchronizer flops.
- R8: Each mode change out of a region pulses the preload valid output for exactly one clock, together with the gate switch. The duty value is all ones (1023 at 10 bits) for an upward change and zero for a downward one. Leaving start-up into middle or high preloads all ones. Leaving start-up into low, and returning to start-up, issue no preload.
- R9: The upper strobe fires once, at cycle floor(L/2) of each interval in which the second gate is high, where L is the length of the previous such interval. The lower strobe does the same for intervals in which the second gate is low. Both strobes are silent in start-up, and a strobe needs an interval completed outside start-up.
- R10: Reset drives both gates, the preload valid and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM from the current loop, synchronous to clk |
| cmp_third_in | input | 1 | Input voltage above one third of the bus (asynchronous) |
| cmp_twothird_in | input | 1 | Input voltage above two thirds of the bus (asynchronous) |
| startup_in | input | 1 | Start-up flag, synchronous |
| sw1_gate_o | output | 1 | Gate of the divider-tap transistor |
| sw2_gate_o | output | 1 | Gate of the lower-cell transistor |
| preload_vld_o | output | 1 | One-clock compensator preload command |
| preload_duty_o | output | DUTY_W | Preload duty value, zero or full scale |
| stb_top_o | output | 1 | Sample strobe for the upper divider cell |
| stb_bot_o | output | 1 | Sample strobe for the lower cell and the bus |

## Verification
Gates change one clock after the PWM sample that drives them. A comparator change becomes visible two clocks after it is driven, and the mode then changes at the second qualifying rising edge. The bench therefore applies comparator changes several clocks before a period starts, and checks the gates at the falling clock edge that ends each PWM phase, when the last sampled PWM value has settled through the single gate register. The preload pulse lands on the clock after the rising edge, and each strobe lands floor(L/2) clocks into its interval. Both are counted by a falling-edge monitor over a whole period, which records the position of each strobe within the interval, so a pulse that is early, late, doubled or missing is reported.

// File: rtl/mlb_pkg.sv
package mlb_pkg;

    typedef enum logic [1:0] {
        MS_BOOT = 2'd0,
        MS_LOW  = 2'd1,
        MS_MID  = 2'd2,
        MS_HIGH = 2'd3
    } mode_e;

    typedef struct packed {
        logic sw1;
        logic sw2;
    } gate_t;

    // Region decode: the two-thirds comparator has priority.
    function automatic mode_e region_of(input logic third, input logic twothird);
        if (twothird)   return MS_HIGH;
        else if (third) return MS_MID;
        else            return MS_LOW;
    endfunction

    // One step toward the target region.
    function automatic mode_e step_mode(input mode_e cur, input logic up);
        mode_e r;
        case (cur)
            MS_LOW:  r = up ? MS_MID  : MS_LOW;
            MS_MID:  r = up ? MS_HIGH : MS_LOW;
            MS_HIGH: r = up ? MS_HIGH : MS_MID;
            default: r = cur;
        endcase
        return r;
    endfunction

    // Transistor mapping per mode, keeping the node swing at one third of the bus.
    function automatic gate_t map_gates(input mode_e m, input logic pwm);
        gate_t g;
        case (m)
            MS_LOW:  begin g.sw1 = 1'b1; g.sw2 = pwm;  end
            MS_MID:  begin g.sw1 = pwm;  g.sw2 = !pwm; end
            MS_HIGH: begin g.sw1 = 1'b0; g.sw2 = pwm;  end
            default: begin g.sw1 = pwm;  g.sw2 = pwm;  end
        endcase
        return g;
    endfunction

endpackage

// File: rtl/mlb_sync.sv
module mlb_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mlb_mode_ctrl.sv
module mlb_mode_ctrl
    import mlb_pkg::*;
#(
    parameter int PERSIST = 2,
    parameter int DUTY_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              startup,
    input  mode_e             region,
    output mode_e             mode_q,
    output mode_e             mode_nxt,
    output logic              pl_vld_q,
    output logic [DUTY_W-1:0] pl_duty_q
);
    localparam int HIT_W = $clog2(PERSIST + 1);
    localparam logic [HIT_W-1:0] HIT_LIM = HIT_W'(PERSIST);

    logic [HIT_W-1:0] hits_q, hits_nxt;
    logic             up_q, up_nxt, up_now;
    logic             pl_vld, pl_full;

    always_comb begin
        mode_nxt = mode_q;
        hits_nxt = hits_q;
        up_nxt   = up_q;
        pl_vld   = 1'b0;
        pl_full  = 1'b0;
        up_now   = (region > mode_q);
        if (boundary) begin
            if (startup) begin
                mode_nxt = MS_BOOT;
                hits_nxt = '0;
            end else if (mode_q == MS_BOOT) begin
                mode_nxt = region;
                hits_nxt = '0;
                pl_vld   = (region != MS_LOW);
                pl_full  = 1'b1;
            end else if (region == mode_q) begin
                hits_nxt = '0;
            end else begin
                if (hits_q != '0 && up_now != up_q) hits_nxt = HIT_W'(1);
                else                                hits_nxt = hits_q + HIT_W'(1);
                up_nxt = up_now;
                if (hits_nxt >= HIT_LIM) begin
                    mode_nxt = step_mode(mode_q, up_now);
                    hits_nxt = '0;
                    pl_vld   = 1'b1;
                    pl_full  = up_now;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MS_BOOT;
            hits_q    <= '0;
            up_q      <= 1'b0;
            pl_vld_q  <= 1'b0;
            pl_duty_q <= '0;
        end else begin
            mode_q   <= mode_nxt;
            hits_q   <= hits_nxt;
            up_q     <= up_nxt;
            pl_vld_q <= pl_vld;
            if (pl_vld) pl_duty_q <= {DUTY_W{pl_full}};
        end
    end
endmodule

// File: rtl/mlb_gate_map.sv
module mlb_gate_map
    import mlb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode_nxt,
    input  logic  pwm,
    output gate_t g_nxt,
    output gate_t g_q
);
    assign g_nxt = map_gates(mode_nxt, pwm);

    always_ff @(posedge clk) begin
        if (rst) g_q <= '0;
        else     g_q <= g_nxt;
    end
endmodule

// File: rtl/mlb_strobe_gen.sv
module mlb_strobe_gen #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic sw2_q,
    input  logic sw2_nxt,
    input  logic boot_q,
    output logic stb_top,
    output logic stb_bot
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_inc;
    logic [CNT_W-1:0] len_q [2];
    logic [1:0]       vld_q;
    logic [1:0]       stb;
    logic             edge_now;

    assign run_inc  = (run_q == CNT_MAX) ? run_q : run_q + 1'b1;
    assign edge_now = (sw2_nxt != sw2_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            vld_q <= '0;
            for (int k = 0; k < 2; k++) len_q[k] <= '0;
        end else begin
            if (edge_now) begin
                run_q        <= '0;
                len_q[sw2_q] <= run_inc;
            end else begin
                run_q <= run_inc;
            end
            if (boot_q)        vld_q        <= '0;
            else if (edge_now) vld_q[sw2_q] <= 1'b1;
        end
    end

    // Index 1: second gate high (upper cell), index 0: second gate low (lower cell).
    for (genvar k = 0; k < 2; k++) begin : g_stb
        assign stb[k] = !boot_q && (sw2_q == k[0]) && vld_q[k]
                        && (run_q == (len_q[k] >> 1));
    end

    assign stb_top = stb[1];
    assign stb_bot = stb[0];
endmodule

// File: rtl/mlb_mode_sel.sv
module mlb_mode_sel
    import mlb_pkg::*;
#(
    parameter int DUTY_W      = 10,
    parameter int SYNC_STAGES = 2,
    parameter int PERSIST     = 2,
    parameter int CNT_W       = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_in,
    input  logic              cmp_third_in,
    input  logic              cmp_twothird_in,
    input  logic              startup_in,
    output logic              sw1_gate_o,
    output logic              sw2_gate_o,
    output logic              preload_vld_o,
    output logic [DUTY_W-1:0] preload_duty_o,
    output logic              stb_top_o,
    output logic              stb_bot_o
);
    logic [1:0] cmp_s;
    logic       pwm_q;
    logic       boundary;
    mode_e      region;
    mode_e      mode_q;
    mode_e      mode_nxt;
    gate_t      g_nxt;
    gate_t      g_q;

    mlb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cmp_twothird_in, cmp_third_in}),
        .q   (cmp_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm_in;
    end

    assign boundary = pwm_in && !pwm_q;
    assign region   = region_of(cmp_s[0], cmp_s[1]);

    mlb_mode_ctrl #(.PERSIST(PERSIST), .DUTY_W(DUTY_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .boundary  (boundary),
        .startup   (startup_in),
        .region    (region),
        .mode_q    (mode_q),
        .mode_nxt  (mode_nxt),
        .pl_vld_q  (preload_vld_o),
        .pl_duty_q (preload_duty_o)
    );

    mlb_gate_map u_map (
        .clk      (clk),
        .rst      (rst),
        .mode_nxt (mode_nxt),
        .pwm      (pwm_in),
        .g_nxt    (g_nxt),
        .g_q      (g_q)
    );

    mlb_strobe_gen #(.CNT_W(CNT_W)) u_stb (
        .clk     (clk),
        .rst     (rst),
        .sw2_q   (g_q.sw2),
        .sw2_nxt (g_nxt.sw2),
        .boot_q  (mode_q == MS_BOOT),
        .stb_top (stb_top_o),
        .stb_bot (stb_bot_o)
    );

    assign sw1_gate_o = g_q.sw1;
    assign sw2_gate_o = g_q.sw2;
endmodule

// File: rtl/mlb_mode_sel_chk.sv
module mlb_mode_sel_chk #(
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              pwm_in,
    input logic              pwm_q,
    input logic [1:0]        mode_q,
    input logic              sw1_gate_o,
    input logic              sw2_gate_o,
    input logic              preload_vld_o,
    input logic [DUTY_W-1:0] preload_duty_o,
    input logic              stb_top_o,
    input logic              stb_bot_o
);
    p_low_sw1_on_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1) |-> sw1_gate_o);

    p_mid_complement_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2) |-> (sw1_gate_o != sw2_gate_o));

    p_high_sw1_off_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd3) |-> !sw1_gate_o);

    p_boot_lockstep_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd0) |-> (sw1_gate_o == sw2_gate_o));

    p_no_skip_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == 2'd1) |-> (mode_q != 2'd3));

    p_change_on_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> ($past(pwm_in) && !$past(pwm_q)));

    p_preload_single_r8: assert property (@(posedge clk) disable iff (rst)
        preload_vld_o |=> !preload_vld_o);

    p_preload_with_change_r8: assert property (@(posedge clk) disable iff (rst)
        preload_vld_o |-> (mode_q != $past(mode_q)));

    p_preload_zero_low_r8: assert property (@(posedge clk) disable iff (rst)
        (preload_vld_o && mode_q == 2'd1) |-> (preload_duty_o == '0));

    p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(stb_top_o && stb_bot_o));

    p_strobe_quiet_boot_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd0) |-> (!stb_top_o && !stb_bot_o));

    p_strobe_one_clock_r9: assert property (@(posedge clk) disable iff (rst)
        stb_top_o |=> !stb_top_o);
endmodule

bind mlb_mode_sel mlb_mode_sel_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pwm_in         (pwm_in),
    .pwm_q          (pwm_q),
    .mode_q         (mode_q),
    .sw1_gate_o     (sw1_gate_o),
    .sw2_gate_o     (sw2_gate_o),
    .preload_vld_o  (preload_vld_o),
    .preload_duty_o (preload_duty_o),
    .stb_top_o      (stb_top_o),
    .stb_bot_o      (stb_bot_o)
);

// File: tb/tb_mlb_mode_sel.sv
module tb_mlb_mode_sel;
    localparam int DUTY_W = 10;
    localparam int FULL   = (1 << DUTY_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm = 1'b0;
    logic c3 = 1'b0, c23 = 1'b0, st = 1'b1;
    logic sw1, sw2, plv, stt, stb;
    logic [DUTY_W-1:0] pld;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Monitor state (sampled at falling edges)
    int npl = 0, plval = 0, ntop = 0, nbot = 0, top_pos = -1, bot_pos = -1, pos = 0;
    logic last_sw2 = 1'b0;
    // Per-period deltas
    int d_pl, d_top, d_bot;

    always #5 clk = ~clk;

    mlb_mode_sel #(.DUTY_W(DUTY_W)) dut (
        .clk (clk), .rst (rst), .pwm_in (pwm),
        .cmp_third_in (c3), .cmp_twothird_in (c23), .startup_in (st),
        .sw1_gate_o (sw1), .sw2_gate_o (sw2),
        .preload_vld_o (plv), .preload_duty_o (pld),
        .stb_top_o (stt), .stb_bot_o (stb)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sw2 != last_sw2) pos = 0; else pos = pos + 1;
            last_sw2 = sw2;
            if (plv) begin npl = npl + 1; plval = int'(pld); end
            if (stt) begin ntop = ntop + 1; top_pos = pos; end
            if (stb) begin nbot = nbot + 1; bot_pos = pos; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected gate pair {sw1,sw2} per mode code for a given PWM level.
    function automatic int exp_gates(input int m, input logic p);
        case (m)
            1: return {1'b1, p};
            2: return {p, !p};
            3: return {1'b0, p};
            default: return {p, p};
        endcase
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cmp(input logic a, input logic b);
        c3 = a; c23 = b;
        idle(4);
    endtask

    // One PWM period; gates checked at the end of each phase, preload delta over the period.
    task automatic period(input int on, input int off, input int m,
                          input int pl_d, input int pl_v, input string req);
        int p0, t0, b0;
        p0 = npl; t0 = ntop; b0 = nbot;
        pwm = 1'b1;
        idle(on);
        chk({sw1, sw2} == exp_gates(m, 1'b1), {req, " on-phase gates"}, int'({sw1, sw2}), exp_gates(m, 1'b1));
        pwm = 1'b0;
        idle(off);
        chk({sw1, sw2} == exp_gates(m, 1'b0), {req, " off-phase gates"}, int'({sw1, sw2}), exp_gates(m, 1'b0));
        d_pl = npl - p0; d_top = ntop - t0; d_bot = nbot - b0;
        chk(d_pl == pl_d, {req, " preload count"}, d_pl, pl_d);
        if (pl_d != 0) chk(plval == pl_v, {req, " preload value"}, plval, pl_v);
    endtask

    task automatic t_reset();
        // R10: outputs low out of reset
        chk({sw1, sw2, plv, stt, stb} == 5'b0, "R10 reset outputs", int'({sw1, sw2, plv, stt, stb}), 0);
    endtask

    task automatic t_boot();
        // R4: start-up mapping, R7: one clock gate latency, R9: silent strobes
        pwm = 1'b1;
        #1 chk(sw2 == 1'b0, "R7 gate before sampling", int'(sw2), 0);
        @(negedge clk);
        chk({sw1, sw2} == 2'b11, "R7 gate one clock after pwm", int'({sw1, sw2}), 3);
        pwm = 1'b0; idle(8);
        period(6, 10, 0, 0, 0, "R4 start-up");
        period(6, 10, 0, 0, 0, "R4 start-up again");
        chk(ntop + nbot == 0, "R9 no strobes in start-up", ntop + nbot, 0);
    endtask

    task automatic t_exit_low();
        st = 1'b0; set_cmp(1'b0, 1'b0);
        period(6, 10, 1, 0, 0, "R1 low region after start-up (R8 no preload)");
        period(6, 10, 1, 0, 0, "R1 low region held");
    endtask

    task automatic t_low_mid();
        set_cmp(1'b1, 1'b0);
        period(6, 10, 1, 0, 0, "R6 first qualifying edge keeps low");
        period(6, 10, 2, 1, FULL, "R2 middle region, R8 upward preload");
    endtask

    task automatic t_chatter();
        set_cmp(1'b1, 1'b1); period(6, 10, 2, 0, 0, "R6 chatter 1");
        set_cmp(1'b1, 1'b0); period(6, 10, 2, 0, 0, "R6 chatter 2");
        set_cmp(1'b1, 1'b1); period(6, 10, 2, 0, 0, "R6 chatter 3");
        set_cmp(1'b1, 1'b0); period(6, 10, 2, 0, 0, "R6 chatter 4");
        // middle region: second gate high for 10 cycles, low for 6
        period(6, 10, 2, 0, 0, "R9 middle strobe period");
        chk(d_top == 1 && top_pos == 5, "R9 upper strobe in middle region", top_pos, 5);
        chk(d_bot == 1 && bot_pos == 3, "R9 lower strobe in middle region", bot_pos, 3);
    endtask

    task automatic t_mid_high();
        set_cmp(1'b1, 1'b1);
        period(8, 12, 2, 0, 0, "R6 middle held one edge");
        period(8, 12, 3, 1, FULL, "R3 high region, R8 upward preload");
    endtask

    task automatic t_strobe();
        period(8, 12, 3, 0, 0, "R9 warm-up");
        period(8, 12, 3, 0, 0, "R9 measured");
        chk(d_top == 1 && top_pos == 4, "R9 upper strobe mid on-interval", top_pos, 4);
        chk(d_bot == 1 && bot_pos == 6, "R9 lower strobe mid off-interval", bot_pos, 6);
    endtask

    task automatic t_fall();
        set_cmp(1'b1, 1'b0);
        period(6, 10, 3, 0, 0, "R6 high held one edge");
        period(6, 10, 2, 1, 0, "R8 downward preload high to middle");
        set_cmp(1'b0, 1'b0);
        period(6, 10, 2, 0, 0, "R6 middle held one edge");
        period(6, 10, 1, 1, 0, "R8 downward preload middle to low");
    endtask

    task automatic t_jump();
        set_cmp(1'b1, 1'b1);
        period(6, 10, 1, 0, 0, "R5 jump edge 1");
        period(6, 10, 2, 1, FULL, "R5 low to high passes middle");
        period(6, 10, 2, 0, 0, "R5 jump edge 3");
        period(6, 10, 3, 1, FULL, "R5 reaches high");
    endtask

    task automatic t_reboot();
        st = 1'b1; idle(2);
        period(6, 10, 0, 0, 0, "R4 return to start-up, R8 no preload");
        st = 1'b0; set_cmp(1'b1, 1'b0);
        period(6, 10, 2, 1, FULL, "R4 exit straight to middle, R8 full preload");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        rst = 1'b0;
        idle(2);
        t_reset();
        t_boot();
        t_exit_low();
        t_low_mid();
        t_chatter();
        t_mid_high();
        t_strobe();
        t_fall();
        t_jump();
        t_reboot();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule